// File: doc/BRIEF.md
# Vector Mask Generator

This unit builds a 128-bit mask vector from a compact description. It has two modes. In byte-fill mode, a 16-bit immediate sets the mask one byte at a time: each immediate bit decides whether its byte is all ones or all zeros. In run mode, the caller gives an element size and two bit positions. The unit sets a contiguous run of bits inside one element, then copies that element pattern into every lane of the vector. The run wraps around the end of the element when the first position lies after the last one.

The caller presents one request with a single-cycle strobe. The result is registered and comes out on the next clock edge, together with a one-cycle valid pulse. A run-mode request with an element-size code that is not defined returns an error flag and an all-zero mask.

Top module: `vmg_top`

## Requirements
- R1: While reset is high, at the following clock edge `out_mask` becomes all zeros and both `out_valid` and `out_err` become 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1, and 0 otherwise.
- R3: With `in_mode` = 0 (byte-fill), immediate bit k sets bits [8k+7:8k] of the mask to 0xFF when it is 1 and to 0x00 when it is 0, so bit 15 drives bits [127:120]. The size code and both positions are ignored, and `out_err` is 0.
- R4: With `in_mode` = 1 (run), size codes 0, 1, 2 and 3 select element widths of 8, 16, 32 and 64 bits.
- R5: In run mode, only the low log2(width) bits of `in_first` and `in_last` are used, so each position is taken modulo the element width.
- R6: Positions count from the most significant bit of an element: position 0 is element bit width-1, and position width-1 is element bit 0.
- R7: When first <= last, every position from first to last, inclusive, is set, and no other position is set.
- R8: When first > last, positions first up to width-1 and positions 0 up to last are set, and the positions in between are clear.
- R9: When first equals last after reduction, exactly one bit per element is set.
- R10: The pattern of one element is repeated in every lane: element lane n occupies mask bits [n*width+width-1 : n*width].
- R11: In run mode, a size code above 3 makes `out_err` 1 in the result cycle and forces the mask to all zeros.
- R12: In a cycle after `in_valid` was 0, `out_mask` keeps its previous value and `out_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe, one cycle for each request |
| in_mode | input | 1 | 0 selects byte-fill, 1 selects run mode |
| in_esz | input | 3 | Element size code (run mode) |
| in_imm | input | 16 | Byte-fill immediate |
| in_first | input | 6 | First set position of the run |
| in_last | input | 6 | Last set position of the run |
| out_mask | output | 128 | Registered mask |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_err | output | 1 | Undefined size code in run mode |

## Verification
Each result is due on the first rising edge after its strobe. The mask, the valid flag and the error flag all change at that same edge, because there is only one register stage. The bench model updates its expected state at each rising edge from the inputs it drove, and compares all three outputs at the following falling edge. That falling edge is the single cycle in which each expected value is due. Idle cycles and back-to-back strobes are compared in the same way, so the hold behaviour and the valid-pulse spacing are checked in their exact cycles.

// File: rtl/vmg_pkg.sv
`timescale 1ns/1ps
package vmg_pkg;

    localparam int VMG_VEC_W   = 128;
    localparam int VMG_POS_W   = 6;
    localparam int VMG_ESZ_W   = 3;
    localparam int VMG_SIZES   = 4;
    localparam int VMG_BYTE_W  = 8;

    typedef enum logic {
        MODE_BYTES = 1'b0,
        MODE_RUN   = 1'b1
    } vmg_mode_e;

    typedef struct packed {
        logic [VMG_VEC_W-1:0] mask;
        logic                 err;
    } vmg_result_t;

    // Width in bits of an element for a given size code.
    function automatic int elem_bits(input int code);
        return VMG_BYTE_W << code;
    endfunction

    // Log2 of the element width for a given size code.
    function automatic int elem_log2(input int code);
        return 3 + code;
    endfunction

endpackage

// File: rtl/vmg_byte_fill.sv
`timescale 1ns/1ps
module vmg_byte_fill #(
    parameter int VEC_W  = vmg_pkg::VMG_VEC_W,
    parameter int BYTE_W = vmg_pkg::VMG_BYTE_W,
    localparam int NBYTES = VEC_W / BYTE_W
) (
    input  logic [NBYTES-1:0] imm,
    output logic [VEC_W-1:0]  mask
);
    // Each immediate bit is copied into every bit of the byte it selects.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign mask[k*BYTE_W +: BYTE_W] = {BYTE_W{imm[k]}};
    end
endmodule

// File: rtl/vmg_run_lane.sv
`timescale 1ns/1ps
module vmg_run_lane #(
    parameter int VEC_W = vmg_pkg::VMG_VEC_W,
    parameter int CODE  = 0,
    localparam int W    = vmg_pkg::elem_bits(CODE),
    localparam int LW   = vmg_pkg::elem_log2(CODE)
) (
    input  logic [LW-1:0]    first,
    input  logic [LW-1:0]    last,
    output logic [VEC_W-1:0] mask
);
    logic wrap;
    assign wrap = (first > last);

    // Position p counts from the element MSB; bit j of a lane is position W-1-j.
    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        localparam int J = i % W;
        localparam logic [LW-1:0] P = LW'(W - 1 - J);
        logic after_first;
        logic before_last;
        assign after_first = (P >= first);
        assign before_last = (P <= last);
        assign mask[i] = wrap ? (after_first | before_last)
                              : (after_first & before_last);
    end
endmodule

// File: rtl/vmg_run_sel.sv
`timescale 1ns/1ps
module vmg_run_sel #(
    parameter int VEC_W = vmg_pkg::VMG_VEC_W,
    parameter int POS_W = vmg_pkg::VMG_POS_W,
    parameter int ESZ_W = vmg_pkg::VMG_ESZ_W,
    parameter int SIZES = vmg_pkg::VMG_SIZES
) (
    input  logic [ESZ_W-1:0] esz,
    input  logic [POS_W-1:0] first,
    input  logic [POS_W-1:0] last,
    output logic [VEC_W-1:0] mask,
    output logic             err
);
    logic [VEC_W-1:0] lane_mask [SIZES];

    for (genvar c = 0; c < SIZES; c++) begin : g_size
        localparam int LW = vmg_pkg::elem_log2(c);
        vmg_run_lane #(
            .VEC_W (VEC_W),
            .CODE  (c)
        ) u_lane (
            .first (first[LW-1:0]),
            .last  (last[LW-1:0]),
            .mask  (lane_mask[c])
        );
    end

    always_comb begin
        err  = (int'(esz) >= SIZES);
        mask = '0;
        for (int c = 0; c < SIZES; c++) begin
            if (int'(esz) == c) begin
                mask = lane_mask[c];
            end
        end
    end
endmodule

// File: rtl/vmg_top.sv
`timescale 1ns/1ps
module vmg_top #(
    parameter int VEC_W = vmg_pkg::VMG_VEC_W,
    parameter int POS_W = vmg_pkg::VMG_POS_W,
    parameter int ESZ_W = vmg_pkg::VMG_ESZ_W,
    localparam int IMM_W = VEC_W / vmg_pkg::VMG_BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_mode,
    input  logic [ESZ_W-1:0] in_esz,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [POS_W-1:0] in_first,
    input  logic [POS_W-1:0] in_last,
    output logic [VEC_W-1:0] out_mask,
    output logic             out_valid,
    output logic             out_err
);
    import vmg_pkg::*;

    logic [VEC_W-1:0] byte_mask;
    logic [VEC_W-1:0] run_mask;
    logic             run_err;
    vmg_mode_e        mode;
    vmg_result_t      nxt;
    vmg_result_t      res_q;
    logic             valid_q;

    assign mode = vmg_mode_e'(in_mode);

    vmg_byte_fill #(.VEC_W(VEC_W)) u_bytes (
        .imm  (in_imm),
        .mask (byte_mask)
    );

    vmg_run_sel #(
        .VEC_W (VEC_W),
        .POS_W (POS_W),
        .ESZ_W (ESZ_W)
    ) u_run (
        .esz   (in_esz),
        .first (in_first),
        .last  (in_last),
        .mask  (run_mask),
        .err   (run_err)
    );

    always_comb begin
        nxt = '0;
        unique case (mode)
            MODE_BYTES: begin
                nxt.mask = byte_mask;
                nxt.err  = 1'b0;
            end
            MODE_RUN: begin
                nxt.mask = run_err ? '0 : run_mask;
                nxt.err  = run_err;
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= nxt;
            end else begin
                res_q.err <= 1'b0;
            end
        end
    end

    assign out_mask  = res_q.mask;
    assign out_err   = res_q.err;
    assign out_valid = valid_q;
endmodule

// File: rtl/vmg_checker.sv
`timescale 1ns/1ps
module vmg_checker #(
    parameter int VEC_W = 128,
    parameter int POS_W = 6,
    parameter int ESZ_W = 3,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_mode,
    input logic [ESZ_W-1:0] in_esz,
    input logic [IMM_W-1:0] in_imm,
    input logic [POS_W-1:0] in_first,
    input logic [POS_W-1:0] in_last,
    input logic [VEC_W-1:0] out_mask,
    input logic             out_valid,
    input logic             out_err
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_err && out_mask == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_top_byte: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode) |=>
            (out_mask[VEC_W-1 -: 8] == {8{$past(in_imm[IMM_W-1])}} && !out_err));

    a_r3_low_byte: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode) |=> (out_mask[7:0] == {8{$past(in_imm[0])}}));

    a_r9_single_bit_bytes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode && in_esz == 3'd0 && in_first[2:0] == in_last[2:0])
            |=> ($countones(out_mask) == 16));

    a_r9_single_bit_dwords: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode && in_esz == 3'd3 && in_first == in_last)
            |=> ($countones(out_mask) == 2));

    a_r11_bad_size: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode && in_esz > 3'd3) |=> (out_err && out_mask == '0));

    a_r12_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_mask) && !out_err));
endmodule

bind vmg_top vmg_checker #(
    .VEC_W (VEC_W),
    .POS_W (POS_W),
    .ESZ_W (ESZ_W),
    .IMM_W (IMM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_esz    (in_esz),
    .in_imm    (in_imm),
    .in_first  (in_first),
    .in_last   (in_last),
    .out_mask  (out_mask),
    .out_valid (out_valid),
    .out_err   (out_err)
);

// File: tb/sim_vmg_top.sv
`timescale 1ns/1ps
module sim_vmg_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_mode = 1'b0;
    logic [2:0]   in_esz = '0;
    logic [15:0]  in_imm = '0;
    logic [5:0]   in_first = '0;
    logic [5:0]   in_last = '0;
    logic [127:0] out_mask;
    logic         out_valid;
    logic         out_err;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R1";
    string exp_tag = "R1";
    logic [127:0] exp_mask = '0;
    logic         exp_valid = 1'b0;
    logic         exp_err = 1'b0;
    bit           done = 0;

    always #10 clk = ~clk;

    vmg_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_esz(in_esz), .in_imm(in_imm), .in_first(in_first),
        .in_last(in_last), .out_mask(out_mask), .out_valid(out_valid),
        .out_err(out_err)
    );

    // Behavioural reference: walks the run position by position.
    function automatic logic [127:0] model_run(int code, int f, int l);
        logic [127:0] m = '0;
        logic [63:0]  elem = '0;
        int w = 8 << code;
        int s = f % w;
        int e = l % w;
        int p = s;
        forever begin
            elem[w-1-p] = 1'b1;
            if (p == e) break;
            p = (p + 1) % w;
        end
        for (int lane = 0; lane < 128 / w; lane++)
            for (int j = 0; j < w; j++)
                m[lane*w + j] = elem[j];
        return m;
    endfunction

    function automatic logic [127:0] model_bytes(logic [15:0] imm);
        logic [127:0] m = '0;
        for (int b = 0; b < 16; b++)
            if (imm[b]) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    always @(posedge clk) begin
        exp_tag = cur_tag;
        if (rst) begin
            exp_mask = '0; exp_valid = 0; exp_err = 0;
        end else begin
            exp_valid = in_valid;
            exp_err = 0;
            if (in_valid) begin
                if (!in_mode) exp_mask = model_bytes(in_imm);
                else if (in_esz > 3) begin exp_mask = '0; exp_err = 1; end
                else exp_mask = model_run(int'(in_esz), int'(in_first), int'(in_last));
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_valid !== exp_valid) begin
                errors++;
                $display("FAIL %s valid: actual=%0b expected=%0b", exp_tag, out_valid, exp_valid);
            end
            checks++;
            if (out_err !== exp_err) begin
                errors++;
                $display("FAIL %s err: actual=%0b expected=%0b", exp_tag, out_err, exp_err);
            end
            checks++;
            if (out_mask !== exp_mask) begin
                errors++;
                $display("FAIL %s mask: actual=%h expected=%h", exp_tag, out_mask, exp_mask);
            end
        end
    end

    task automatic req(input logic mode, input int esz, input logic [15:0] imm,
                       input int f, input int l, input string tag);
        in_valid = 1; in_mode = mode; in_esz = 3'(esz); in_imm = imm;
        in_first = 6'(f); in_last = 6'(l); cur_tag = tag;
        @(negedge clk);
        in_valid = 0; cur_tag = "R12";
    endtask

    task automatic idle(input int n);
        cur_tag = "R12";
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] lfsr = 32'h1234_5678;
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        req(0, 0, 16'hA55A, 0, 0, "R3");
        idle(2);                                   // R12 hold
        req(0, 7, 16'h8001, 9, 3, "R3");           // size and positions ignored
        req(1, 0, 0, 2, 5, "R7");
        req(1, 1, 0, 3, 12, "R4");
        req(1, 2, 0, 0, 0, "R6");
        req(1, 3, 0, 63, 63, "R9");
        req(1, 0, 0, 7, 7, "R9");
        req(1, 3, 0, 60, 3, "R8");
        req(1, 0, 0, 6, 1, "R8");
        req(1, 2, 0, 40, 33, "R5");
        req(1, 0, 0, 13, 58, "R5");
        req(1, 1, 0, 15, 0, "R10");
        req(1, 4, 16'hFFFF, 0, 63, "R11");
        idle(1);
        req(1, 7, 0, 1, 2, "R11");
        req(1, 3, 0, 0, 63, "R7");
        idle(3);
        for (int i = 0; i < 40; i++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            req(lfsr[31], int'(lfsr[2:0]), lfsr[23:8], int'(lfsr[29:24]),
                int'(lfsr[13:8]), "R10");
            if (lfsr[4]) idle(1);
        end
        rst = 1; cur_tag = "R1";
        @(negedge clk);
        rst = 0;
        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule